// File: doc/BRIEF.md
# Serial Hex Monitor with Range Load and Range Checksum

This block interprets a stream of ASCII characters from an external UART receiver. It gives a host direct access to a byte-addressed memory through a synchronous read/write port. Every command opens with `>` (0x3E). Two uppercase letters follow: `LH` loads a range and `CS` sums a range. Then come a single space, a start address in hex, a single space, an end address in hex, and a carriage return (0x0D). After a load command the host streams bare hex digits. There are no separators, no framing and no integrity check. The count is exactly enough digits to fill the inclusive range, after which the block returns to command mode. After a checksum command the block reads the range and sends back the 32-bit byte sum in hex.

The monitor stays dormant until every boot-source failure flag has been raised while the security key input reads zero. Once armed, it stays armed. However, any nonzero key silences every output in the same cycle and forces the machine back to its off state.

The state machine has these states:
- `ST_OFF`: dormant.
- `ST_IDLE`: waits for `>`.
- `ST_MN1` and `ST_MN2`: take the mnemonic letters.
- `ST_SEP`: takes the first space.
- `ST_ADA`: collects the start digits and ends on a space.
- `ST_ADB`: collects the end digits and ends on CR.
- `ST_RANGE`: compares the two addresses.
- `ST_LDHI` and `ST_LDLO`: take the two digits of each data byte.
- `ST_SUMRD`: issues one read per cycle.
- `ST_SUMEND`: absorbs the last read.
- `ST_TXHEX` and `ST_TXCR`: send the reply.
- `ST_ERR`: sends `?`.

The transitions are:
- `ST_OFF` → `ST_IDLE` once the block is live.
- `ST_IDLE` → `ST_MN1` on `>`.
- `ST_MN1` → `ST_MN2` → `ST_SEP` on a known mnemonic.
- `ST_SEP` → `ST_ADA` on a space.
- `ST_ADA` → `ST_ADB` on a space.
- `ST_ADB` → `ST_RANGE` on CR.
- `ST_RANGE` → `ST_LDHI` for a load, `ST_SUMRD` for a sum, or `ST_ERR` for a reversed range.
- `ST_LDHI` ↔ `ST_LDLO` until the last byte, then `ST_LDLO` → `ST_IDLE`.
- `ST_SUMRD` → `ST_SUMEND` → `ST_TXHEX` → `ST_TXCR` → `ST_IDLE`.
- Any parse state → `ST_ERR` on a bad character, then `ST_ERR` → `ST_IDLE`.
- Every state → `ST_OFF` when the block is not live.

Top module: `hexmon_top`

## Requirements
- R1: With the key at zero, `rx_ready`, `tx_valid`, `mem_we` and `mem_re` stay low until a cycle in which every `boot_fail` bit is high. Two cycles after that cycle, `rx_ready` is high.
- R2: While `sec_key` is nonzero, `rx_ready`, `tx_valid`, `mem_we` and `mem_re` are all low in that same cycle. A run in progress is abandoned.
- R3: The command syntax is `>`, then `LH` or `CS` in uppercase, one space (0x20), start hex, one space, end hex, and CR (0x0D). Hex digits are 0-9, A-F or a-f. Each address keeps only its low ADDR_W bits, so extra leading digits are dropped.
- R4: After a valid `LH`, exactly 2*(end-start+1) digits are consumed, high nibble first. Each completed pair writes one byte at ascending addresses from start. `mem_we` is high in the cycle the second digit is accepted.
- R5: A valid `CS` performs one read per address of the range and then sends 8 uppercase hex digits, most significant first, followed by CR. The value is the sum of the bytes modulo 2^32. Read data is taken one cycle after `mem_re`.
- R6: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` is unchanged.
- R7: An end address below the start address sends `?` (0x3F) and causes no memory read or write.
- R8: A bad character aborts the command, sends `?`, and leaves already completed bytes written with no further writes. Bad characters are: a non-hex character in an address field or data stream, a wrong separator, an empty address field, or an unknown mnemonic.
- R9: In command mode every character other than `>` is discarded, with no write and no reply. This includes hex digits sent after a load has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_key | input | KEY_W | Security key; nonzero disables the monitor |
| boot_fail | input | BOOT_N | One failure flag per boot source |
| rx_data | input | 8 | Received character |
| rx_valid | input | 1 | Received character present |
| rx_ready | output | 1 | Monitor accepts the character this cycle |
| tx_data | output | 8 | Character to transmit |
| tx_valid | output | 1 | Transmit character present |
| tx_ready | input | 1 | Transmitter takes the character this cycle |
| mem_addr | output | ADDR_W | Byte address for read or write |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_re | output | 1 | Read strobe |
| mem_rdata | input | 8 | Read data, valid one cycle after `mem_re` |

## Verification
The bench builds the block with an 8-bit address, a 4-bit key and three boot sources. With these values, the whole 256-byte space can be filled by one load and checked byte for byte. A grid of checksum ranges covers single bytes, the full space and reversed ranges, and it runs under pseudo-random transmit backpressure. The narrow address also makes the dropping of surplus leading address digits visible in a short command.

// File: rtl/hexmon_pkg.sv
package hexmon_pkg;
    localparam int SUM_W   = 32;
    localparam int SUM_DIG = SUM_W / 4;
    localparam int IDX_W   = $clog2(SUM_DIG);

    localparam logic [7:0] CH_OPEN = 8'h3E;
    localparam logic [7:0] CH_SP   = 8'h20;
    localparam logic [7:0] CH_CR   = 8'h0D;
    localparam logic [7:0] CH_BAD  = 8'h3F;
    localparam logic [15:0] MN_LOAD = 16'h4C48;
    localparam logic [15:0] MN_SUM  = 16'h4353;

    typedef enum logic [3:0] {
        ST_OFF, ST_IDLE, ST_MN1, ST_MN2, ST_SEP, ST_ADA, ST_ADB, ST_RANGE,
        ST_LDHI, ST_LDLO, ST_SUMRD, ST_SUMEND, ST_TXHEX, ST_TXCR, ST_ERR
    } mon_state_e;

    typedef enum logic {OP_LOAD, OP_SUM} mon_op_e;

    function automatic logic [7:0] nib_to_asc(input logic [3:0] n);
        return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h37 + {4'h0, n});
    endfunction
endpackage

// File: rtl/hexmon_arm.sv
module hexmon_arm #(
    parameter int KEY_W  = 8,
    parameter int BOOT_N = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [KEY_W-1:0]  sec_key,
    input  logic [BOOT_N-1:0] boot_fail,
    output logic              live
);
    logic armed_q;
    logic key_zero;

    assign key_zero = (sec_key == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            armed_q <= 1'b0;
        else if (key_zero && (&boot_fail))
            armed_q <= 1'b1;
    end

    assign live = armed_q && key_zero;
endmodule

// File: rtl/hexmon_nibdec.sv
module hexmon_nibdec (
    input  logic [7:0] ch,
    output logic       ok,
    output logic [3:0] nib
);
    always_comb begin
        ok  = 1'b1;
        nib = 4'h0;
        if (ch >= 8'h30 && ch <= 8'h39)
            nib = ch[3:0];
        else if ((ch >= 8'h41 && ch <= 8'h46) || (ch >= 8'h61 && ch <= 8'h66))
            nib = ch[3:0] + 4'd9;
        else
            ok = 1'b0;
    end
endmodule

// File: rtl/hexmon_sumacc.sv
module hexmon_sumacc #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         add,
    input  logic [7:0]   din,
    output logic [W-1:0] sum
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sum <= '0;
        else if (clr)
            sum <= '0;
        else if (add)
            sum <= sum + {{(W-8){1'b0}}, din};
    end
endmodule

// File: rtl/hexmon_top.sv
module hexmon_top
    import hexmon_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int KEY_W  = 8,
    parameter int BOOT_N = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [KEY_W-1:0]  sec_key,
    input  logic [BOOT_N-1:0] boot_fail,
    input  logic [7:0]        rx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [7:0]        mem_wdata,
    output logic              mem_re,
    input  logic [7:0]        mem_rdata
);
    mon_state_e        st_q, st_n;
    mon_op_e           op_q, op_n;
    logic [7:0]        first_q, first_n;
    logic [ADDR_W-1:0] a_q, a_n;
    logic [ADDR_W-1:0] b_q, b_n;
    logic              dig_q, dig_n;
    logic [3:0]        hi_q, hi_n;
    logic [IDX_W-1:0]  idx_q, idx_n;
    logic              pend_q;
    logic              sum_clr;
    logic              live;
    logic              take;
    logic              is_hex;
    logic [3:0]        nib;
    logic [SUM_W-1:0]  sum;

    hexmon_arm #(.KEY_W(KEY_W), .BOOT_N(BOOT_N)) u_arm (
        .clk(clk), .rst_n(rst_n), .sec_key(sec_key),
        .boot_fail(boot_fail), .live(live)
    );

    hexmon_nibdec u_dec (.ch(rx_data), .ok(is_hex), .nib(nib));

    hexmon_sumacc #(.W(SUM_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .clr(sum_clr), .add(pend_q),
        .din(mem_rdata), .sum(sum)
    );

    assign take = rx_valid && rx_ready;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ST_OFF;
            op_q    <= OP_LOAD;
            first_q <= 8'h00;
            a_q     <= '0;
            b_q     <= '0;
            dig_q   <= 1'b0;
            hi_q    <= 4'h0;
            idx_q   <= '0;
            pend_q  <= 1'b0;
        end else begin
            st_q    <= st_n;
            op_q    <= op_n;
            first_q <= first_n;
            a_q     <= a_n;
            b_q     <= b_n;
            dig_q   <= dig_n;
            hi_q    <= hi_n;
            idx_q   <= idx_n;
            pend_q  <= live && (st_q == ST_SUMRD);
        end
    end

    // next state
    always_comb begin
        st_n    = st_q;
        op_n    = op_q;
        first_n = first_q;
        a_n     = a_q;
        b_n     = b_q;
        dig_n   = dig_q;
        hi_n    = hi_q;
        idx_n   = idx_q;
        sum_clr = 1'b0;
        if (!live) begin
            st_n = ST_OFF;
        end else begin
            unique case (st_q)
                ST_OFF: st_n = ST_IDLE;
                ST_IDLE: begin
                    if (take && rx_data == CH_OPEN) st_n = ST_MN1;
                end
                ST_MN1: begin
                    if (take) begin
                        first_n = rx_data;
                        st_n    = ST_MN2;
                    end
                end
                ST_MN2: begin
                    if (take) begin
                        if ({first_q, rx_data} == MN_LOAD) begin
                            op_n = OP_LOAD;
                            st_n = ST_SEP;
                        end else if ({first_q, rx_data} == MN_SUM) begin
                            op_n = OP_SUM;
                            st_n = ST_SEP;
                        end else begin
                            st_n = ST_ERR;
                        end
                    end
                end
                ST_SEP: begin
                    if (take) begin
                        if (rx_data == CH_SP) begin
                            st_n  = ST_ADA;
                            a_n   = '0;
                            dig_n = 1'b0;
                        end else begin
                            st_n = ST_ERR;
                        end
                    end
                end
                ST_ADA: begin
                    if (take) begin
                        if (is_hex) begin
                            a_n   = {a_q[ADDR_W-5:0], nib};
                            dig_n = 1'b1;
                        end else if (rx_data == CH_SP && dig_q) begin
                            st_n  = ST_ADB;
                            b_n   = '0;
                            dig_n = 1'b0;
                        end else begin
                            st_n = ST_ERR;
                        end
                    end
                end
                ST_ADB: begin
                    if (take) begin
                        if (is_hex) begin
                            b_n   = {b_q[ADDR_W-5:0], nib};
                            dig_n = 1'b1;
                        end else if (rx_data == CH_CR && dig_q) begin
                            st_n = ST_RANGE;
                        end else begin
                            st_n = ST_ERR;
                        end
                    end
                end
                ST_RANGE: begin
                    if (b_q < a_q) begin
                        st_n = ST_ERR;
                    end else if (op_q == OP_LOAD) begin
                        st_n = ST_LDHI;
                    end else begin
                        st_n    = ST_SUMRD;
                        sum_clr = 1'b1;
                    end
                end
                ST_LDHI: begin
                    if (take) begin
                        if (is_hex) begin
                            hi_n = nib;
                            st_n = ST_LDLO;
                        end else begin
                            st_n = ST_ERR;
                        end
                    end
                end
                ST_LDLO: begin
                    if (take) begin
                        if (!is_hex) begin
                            st_n = ST_ERR;
                        end else if (a_q == b_q) begin
                            st_n = ST_IDLE;
                        end else begin
                            a_n  = a_q + 1'b1;
                            st_n = ST_LDHI;
                        end
                    end
                end
                ST_SUMRD: begin
                    if (a_q == b_q) st_n = ST_SUMEND;
                    else            a_n  = a_q + 1'b1;
                end
                ST_SUMEND: begin
                    st_n  = ST_TXHEX;
                    idx_n = IDX_W'(SUM_DIG - 1);
                end
                ST_TXHEX: begin
                    if (tx_ready) begin
                        if (idx_q == '0) st_n  = ST_TXCR;
                        else             idx_n = idx_q - 1'b1;
                    end
                end
                ST_TXCR: begin
                    if (tx_ready) st_n = ST_IDLE;
                end
                ST_ERR: begin
                    if (tx_ready) st_n = ST_IDLE;
                end
                default: st_n = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        rx_ready  = 1'b0;
        tx_valid  = 1'b0;
        tx_data   = 8'h00;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_addr  = a_q;
        mem_wdata = {hi_q, nib};
        if (live) begin
            unique case (st_q)
                ST_IDLE, ST_MN1, ST_MN2, ST_SEP, ST_ADA, ST_ADB, ST_LDHI:
                    rx_ready = 1'b1;
                ST_LDLO: begin
                    rx_ready = 1'b1;
                    mem_we   = rx_valid && is_hex;
                end
                ST_SUMRD: mem_re = 1'b1;
                ST_TXHEX: begin
                    tx_valid = 1'b1;
                    tx_data  = nib_to_asc(sum[{idx_q, 2'b00} +: 4]);
                end
                ST_TXCR: begin
                    tx_valid = 1'b1;
                    tx_data  = CH_CR;
                end
                ST_ERR: begin
                    tx_valid = 1'b1;
                    tx_data  = CH_BAD;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/hexmon_chk.sv
module hexmon_chk #(
    parameter int ADDR_W = 16,
    parameter int KEY_W  = 8,
    parameter int BOOT_N = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [KEY_W-1:0]  sec_key,
    input logic [BOOT_N-1:0] boot_fail,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic [7:0]        tx_data,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_we,
    input logic              mem_re
);
    logic seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            seen_q <= 1'b0;
        else if ((&boot_fail) && sec_key == '0)
            seen_q <= 1'b1;
    end

    // R1
    boot_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> (!rx_ready && !tx_valid && !mem_we && !mem_re));

    // R2
    key_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_key != '0) |-> (!rx_ready && !tx_valid && !mem_we && !mem_re));

    // R6
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && sec_key == '0) |=>
        ((sec_key != '0) || (tx_valid && $stable(tx_data))));

    // R4
    wr_on_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (rx_valid && rx_ready));

    // R5
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    // R5
    reply_silent_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid || mem_re) |-> !rx_ready);
endmodule

bind hexmon_top hexmon_chk #(.ADDR_W(ADDR_W), .KEY_W(KEY_W), .BOOT_N(BOOT_N)) u_chk (
    .clk(clk), .rst_n(rst_n), .sec_key(sec_key), .boot_fail(boot_fail),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_re(mem_re)
);

// File: tb/hexmon_top_bench.sv
module hexmon_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int KW = 4;
    localparam int BN = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [KW-1:0] sec_key;
    logic [BN-1:0] boot_fail;
    logic [7:0]    rx_data;
    logic          rx_valid;
    logic          rx_ready;
    logic [7:0]    tx_data;
    logic          tx_valid;
    logic          tx_ready;
    logic [AW-1:0] mem_addr;
    logic          mem_we;
    logic [7:0]    mem_wdata;
    logic          mem_re;
    logic [7:0]    mem_rdata;

    logic [7:0] mem [256];
    logic [7:0] expmem [256];
    logic [7:0] txbuf [64];
    int txn = 0;
    int wr_cnt = 0;
    int rd_cnt = 0;
    int vec = 0;
    int miss = 0;
    logic bp_on = 1'b0;
    logic hold_tx = 1'b0;
    logic [7:0] lfsr = 8'h5B;

    always #(CLK_PERIOD/2) clk = ~clk;

    hexmon_top #(.ADDR_W(AW), .KEY_W(KW), .BOOT_N(BN)) u_hexmon_top (
        .clk(clk), .rst_n(rst_n), .sec_key(sec_key), .boot_fail(boot_fail),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_re(mem_re), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (mem_re) begin
            mem_rdata <= mem[mem_addr];
            rd_cnt <= rd_cnt + 1;
        end
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        tx_ready <= hold_tx ? 1'b0 : (bp_on ? lfsr[0] : 1'b1);
    end

    always @(negedge clk) begin
        if (tx_valid && tx_ready) begin
            txbuf[txn % 64] <= tx_data;
            txn <= txn + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vec++;
        if (!ok) begin
            miss++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] hexc(input int n, input bit lc);
        if (n < 10) return 8'(8'h30 + n);
        return 8'((lc ? 8'h57 : 8'h37) + n);
    endfunction

    task automatic put(input logic [7:0] b);
        rx_data  = b;
        rx_valid = 1'b1;
        while (!rx_ready) @(negedge clk);
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic put_hex(input int v, input int nd, input bit lc);
        for (int k = nd - 1; k >= 0; k--) put(hexc((v >> (4 * k)) & 15, lc));
    endtask

    task automatic cmd(input logic [7:0] m1, input logic [7:0] m2, input int s, input int e);
        put(8'h3E); put(m1); put(m2); put(8'h20);
        put_hex(s, 2, 1'b0); put(8'h20); put_hex(e, 2, 1'b0); put(8'h0D);
    endtask

    task automatic wait_tx(input int base, input int n);
        int t = 0;
        while ((txn - base) < n && t < 4000) begin
            @(negedge clk);
            t++;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic load(input int s, input int e, input int seed);
        int w0 = wr_cnt;
        cmd(8'h4C, 8'h48, s, e);
        for (int a = s; a <= e; a++) begin
            int v = (a * seed + 11) & 255;
            put_hex(v, 2, a[0]);
            expmem[a] = 8'(v);
        end
        repeat (2) @(negedge clk);
        // R4: one write per byte of the inclusive range
        chk(wr_cnt - w0 == e - s + 1, "R4 write count", wr_cnt - w0, e - s + 1);
    endtask

    task automatic expect_sum(input int base, input int s, input int e, input int r0);
        logic [31:0] sum = 0;
        for (int a = s; a <= e; a++) sum += {24'h0, expmem[a]};
        for (int k = 0; k < 8; k++)
            chk(txbuf[(base + k) % 64] == hexc((sum >> (28 - 4 * k)) & 15, 1'b0),
                "R5 checksum digit", txbuf[(base + k) % 64], hexc((sum >> (28 - 4 * k)) & 15, 1'b0));
        chk(txbuf[(base + 8) % 64] == 8'h0D, "R5 terminator", txbuf[(base + 8) % 64], 8'h0D);
        chk(rd_cnt - r0 == e - s + 1, "R5 read count", rd_cnt - r0, e - s + 1);
    endtask

    task automatic sum_check(input int s, input int e);
        int base = txn;
        int r0 = rd_cnt;
        int w0 = wr_cnt;
        cmd(8'h43, 8'h53, s, e);
        if (e < s) begin
            wait_tx(base, 1);
            // R7: reversed range
            chk(txbuf[base % 64] == 8'h3F, "R7 reply", txbuf[base % 64], 8'h3F);
            chk(rd_cnt == r0 && wr_cnt == w0, "R7 no access", rd_cnt - r0, 0);
        end else begin
            wait_tx(base, 9);
            expect_sum(base, s, e, r0);
        end
    endtask

    task automatic expect_err(input int base, input string req);
        wait_tx(base, 1);
        chk(txn - base == 1 && txbuf[base % 64] == 8'h3F, req, txbuf[base % 64], 8'h3F);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        miss++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
        $finish;
    end

    initial begin
        int base;
        int w0;
        rst_n = 1'b0; sec_key = '0; boot_fail = 3'b011; rx_valid = 1'b0; rx_data = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        // R1: not all boot sources failed
        chk(!rx_ready && !tx_valid && !mem_we && !mem_re, "R1 dormant", rx_ready, 0);

        sec_key = 4'h3; boot_fail = 3'b111;
        repeat (5) @(negedge clk);
        // R2: nonzero key keeps it off
        chk(!rx_ready && !tx_valid, "R2 key blocks", rx_ready, 0);
        sec_key = 4'h0;
        repeat (2) @(negedge clk);
        // R1: live two cycles after arming
        chk(rx_ready == 1'b1, "R1 wake", rx_ready, 1);

        // R4, R3: fill whole space, mixed-case digits
        load(0, 255, 37);
        for (int a = 0; a < 256; a++)
            chk(mem[a] == expmem[a], "R4 fill byte", mem[a], expmem[a]);

        // R5, R6, R7: checksum grid under backpressure
        bp_on = 1'b1;
        for (int s = 0; s < 256; s += 23) begin
            for (int e = 0; e < 256; e += 31) sum_check(s, e);
            sum_check(s, 255);
        end

        // R4, R9: sub-range load then trailing digits are ignored
        load(16, 19, 5);
        base = txn; w0 = wr_cnt;
        put(8'h31); put(8'h32); put(8'h61);
        repeat (3) @(negedge clk);
        chk(wr_cnt == w0 && txn == base, "R9 ignored digits", wr_cnt - w0, 0);
        chk(mem[20] == expmem[20] && mem[15] == expmem[15], "R4 bounds", mem[20], expmem[20]);
        for (int a = 16; a < 20; a++)
            chk(mem[a] == expmem[a], "R4 subrange byte", mem[a], expmem[a]);

        // R4: single byte, lower case
        cmd(8'h4C, 8'h48, 128, 128);
        put(8'h63); put(8'h33);
        expmem[128] = 8'hC3;
        repeat (2) @(negedge clk);
        chk(mem[128] == 8'hC3, "R4 single byte", mem[128], 8'hC3);

        // R8: bad digit mid-stream
        base = txn; w0 = wr_cnt;
        cmd(8'h4C, 8'h48, 32, 37);
        put_hex(17, 2, 1'b0); put_hex(34, 2, 1'b0); put(8'h47);
        expmem[32] = 8'h11; expmem[33] = 8'h22;
        expect_err(base, "R8 data abort");
        chk(wr_cnt - w0 == 2, "R8 partial writes", wr_cnt - w0, 2);
        chk(mem[32] == 8'h11 && mem[33] == 8'h22 && mem[34] == expmem[34],
            "R8 kept bytes", mem[34], expmem[34]);

        // R8: bad address character
        base = txn;
        put(8'h3E); put(8'h43); put(8'h53); put(8'h20); put(8'h31); put(8'h58);
        expect_err(base, "R8 address abort");
        // R8: unknown mnemonic
        base = txn;
        put(8'h3E); put(8'h5A); put(8'h5A);
        expect_err(base, "R8 mnemonic");
        // R8: missing separator
        base = txn;
        put(8'h3E); put(8'h4C); put(8'h48); put(8'h31);
        expect_err(base, "R8 separator");
        // R8: empty address field
        base = txn;
        put(8'h3E); put(8'h43); put(8'h53); put(8'h20); put(8'h20);
        expect_err(base, "R8 empty field");

        // R9: junk before '>' is discarded, then a command works
        base = txn;
        put(8'h61); put(8'h20); put(8'h0D);
        repeat (3) @(negedge clk);
        chk(txn == base, "R9 junk silent", txn - base, 0);
        sum_check(30, 40);

        // R3: surplus leading address digits are dropped
        base = txn; w0 = rd_cnt;
        put(8'h3E); put(8'h43); put(8'h53); put(8'h20);
        put(8'h31); put(8'h46); put(8'h30); put(8'h20); put(8'h46); put(8'h32); put(8'h0D);
        wait_tx(base, 9);
        expect_sum(base, 240, 242, w0);

        // R2: key raised during a checksum run
        bp_on = 1'b0;
        cmd(8'h43, 8'h53, 0, 255);
        repeat (20) @(negedge clk);
        sec_key = 4'h1;
        #1;
        chk(!rx_ready && !tx_valid && !mem_re && !mem_we, "R2 mid-run", mem_re, 0);
        repeat (3) @(negedge clk);
        chk(!rx_ready && !tx_valid && !mem_re, "R2 held off", rx_ready, 0);
        sec_key = 4'h0;
        repeat (3) @(negedge clk);
        sum_check(0, 3);

        $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
        $finish;
    end
endmodule